// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is an SPI slave that gives an external master read and write access to an 8-bit register file. The chip-side register file sits behind a simple synchronous port. The block runs on the system clock. It resynchronises the chip-select, serial clock and data input, then detects the serial-clock edges internally. Each frame opens with a command byte and continues with one or more data bytes. The command byte holds a direction flag, an address-step flag and a 6-bit register address. Frames longer than one data byte form bursts. In a burst the address either stays fixed or steps by one per byte.

The master launches data on falling serial-clock edges and the slave samples on rising edges. The serial clock idles high while chip-select (active low) is high. A mode input picks one of two pin arrangements. With the mode input low, the slave uses separate input and output pins. With it high, the slave uses one shared bidirectional pin. The slave receives the command on that pin and drives it during the read data phase. The block only supplies data and enable signals; the tri-state buffers belong to the surrounding pad logic. The serial-clock half period must span at least ten system-clock cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, both output enables are low and neither a register write nor a register read is issued.
- R2: The first frame bit is the direction flag (1 = read), the second is the step flag, and bits 2 to 7 are the register address, most significant bit first. The register-file address is the 6-bit address with a zero in bit 6.
- R3: In a write frame, each data byte arrives most significant bit first. It is committed as a single one-cycle write pulse, shortly after the last rising serial-clock edge of that byte. A single write frame takes 16 clocks.
- R4: In a read frame, the register is fetched after the command byte. Its value appears on the output most significant bit first, with each bit changing after a falling serial-clock edge, starting with the edge that begins bit 8.
- R5: The active output enable is low while chip-select is high, throughout any write frame, and during bits 0 to 7 of a read frame. It is high from bit 8 onward of a read frame.
- R6: With the step flag set, each further data byte of a burst uses the next address. The address wraps from 63 to 0.
- R7: With the step flag clear, every data byte of a burst uses the same address. For a write burst, the last byte remains in the register.
- R8: With the mode input high, read data is driven through the shared-pin enable and the separate-output enable stays low. With the mode input low, the reverse holds.
- R9: If chip-select rises in the middle of a byte, that partial byte is not written. Bytes completed earlier in the frame remain written. The next frame is decoded from a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| threeWire | input | 1 | 1 selects the shared-pin arrangement |
| csN | input | 1 | Chip-select, active low |
| spc | input | 1 | Serial clock from the master, idles high |
| sdiIn | input | 1 | Serial data input; in shared-pin mode the receive side of the shared pin |
| sdoData | output | 1 | Separate serial output data |
| sdoOe | output | 1 | Enable for the separate output pin |
| sdioData | output | 1 | Shared-pin output data |
| sdioOe | output | 1 | Enable for the shared pin |
| regAddr | output | 7 | Register-file address |
| regWe | output | 1 | One-cycle register write strobe |
| regWdata | output | 8 | Register write data |
| regRe | output | 1 | One-cycle register read strobe; data is expected on regRdata the next cycle |
| regRdata | input | 8 | Register read data |

## Verification
The bench targets the address wrap from 63 to 0 in a stepping burst. A design that carried into bit 6 would write or read register 64 instead of register 0. It also runs bursts with the step flag clear; a design that stepped regardless would spread the bytes across neighbouring registers. The bench cuts frames off in the middle of a command byte and in the middle of a data byte. A design that committed partial bytes, or kept frame state across chip-select, would issue an extra write or misdecode the next frame. The bench also checks the output enable on every bit. A design that turned the line around early, drove it during writes, or used the wrong pin's enable for the selected mode would be caught there.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Per-cycle strobes from the frame control to the datapath.
  typedef struct packed {
    logic shiftIn;   // rising serial-clock edge: take one input bit
    logic commitWr;  // a write data byte is complete
    logic fetchRd;   // issue a register read for the next output byte
    logic shiftOut;  // falling edge in a read data phase: present next bit
  } ctlStrobe_t;

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[s] <= RESET_VAL;
      end else begin
        if (s == 0) stage[s] <= asyncIn;
        else        stage[s] <= stage[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csS,
  input  logic              spcS,
  input  logic [DATA_W-1:0] rxNext,
  output ctlStrobe_t        strb,
  output logic [ADDR_W-1:0] accessAddr,
  output logic              oe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam int RW_POS = DATA_W - 1;
  localparam int MS_POS = DATA_W - 2;

  logic             spcD;
  logic [CNT_W-1:0] bitCnt;
  logic             inDataQ;
  logic             rwQ;
  logic             msQ;
  logic [ADDR_W-1:0] addrQ;
  logic             oeQ;

  logic riseE, fallE, byteEnd, cmdEnd, dataEnd;
  logic [ADDR_W-1:0] stepAddr;

  always_comb begin
    riseE    = !csS && spcS && !spcD;
    fallE    = !csS && !spcS && spcD;
    byteEnd  = riseE && (bitCnt == LAST_BIT);
    cmdEnd   = byteEnd && !inDataQ;
    dataEnd  = byteEnd && inDataQ;
    stepAddr = msQ ? addrQ + ADDR_W'(1) : addrQ;

    strb.shiftIn  = riseE;
    strb.commitWr = dataEnd && !rwQ;
    strb.fetchRd  = (cmdEnd && rxNext[RW_POS]) || (dataEnd && rwQ);
    strb.shiftOut = fallE && inDataQ && rwQ;

    if (!inDataQ)  accessAddr = rxNext[ADDR_W-1:0];
    else if (rwQ)  accessAddr = stepAddr;
    else           accessAddr = addrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spcD    <= 1'b1;
      bitCnt  <= '0;
      inDataQ <= 1'b0;
      rwQ     <= 1'b0;
      msQ     <= 1'b0;
      addrQ   <= '0;
      oeQ     <= 1'b0;
    end else begin
      spcD <= spcS;
      if (csS) begin
        bitCnt  <= '0;
        inDataQ <= 1'b0;
        oeQ     <= 1'b0;
      end else begin
        if (riseE) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + CNT_W'(1);
        if (cmdEnd) begin
          inDataQ <= 1'b1;
          rwQ     <= rxNext[RW_POS];
          msQ     <= rxNext[MS_POS];
          addrQ   <= rxNext[ADDR_W-1:0];
        end
        if (dataEnd)       addrQ <= stepAddr;
        if (strb.shiftOut) oeQ   <= 1'b1;
      end
    end
  end

  assign oe = oeQ;

  // R5: once chip-select is seen high the line is released on the next cycle
  a_r5_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !oeQ);

  // R5: the output is only ever enabled inside the data phase of a read
  a_r5_drive_read_only: assert property (@(posedge clk) disable iff (!rstN)
    oeQ |-> (rwQ && inDataQ));

  // R6: a completed data byte with stepping on moves to the next address
  a_r6_step_advances: assert property (@(posedge clk) disable iff (!rstN)
    (dataEnd && msQ) |=> (addrQ == $past(addrQ) + ADDR_W'(1)));

  // R7: without stepping the address holds across data bytes
  a_r7_fixed_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dataEnd && !msQ) |=> $stable(addrQ));

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int REG_AW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdiS,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] accessAddr,
  output logic [DATA_W-1:0] rxNext,
  output logic              txBit,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int PAD_W = REG_AW - ADDR_W;

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic              txBitQ;
  logic              loadPend;
  logic [REG_AW-1:0] regAddrQ;
  logic              regWeQ;
  logic              regReQ;
  logic [DATA_W-1:0] regWdataQ;

  assign rxNext = {rxShift[DATA_W-2:0], sdiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      txShift   <= '0;
      txBitQ    <= 1'b0;
      loadPend  <= 1'b0;
      regAddrQ  <= '0;
      regWeQ    <= 1'b0;
      regReQ    <= 1'b0;
      regWdataQ <= '0;
    end else begin
      regWeQ   <= 1'b0;
      regReQ   <= 1'b0;
      loadPend <= regReQ;
      if (strb.shiftIn) rxShift <= rxNext;
      if (strb.commitWr) begin
        regWeQ    <= 1'b1;
        regAddrQ  <= {{PAD_W{1'b0}}, accessAddr};
        regWdataQ <= rxNext;
      end
      if (strb.fetchRd) begin
        regReQ   <= 1'b1;
        regAddrQ <= {{PAD_W{1'b0}}, accessAddr};
      end
      if (loadPend) begin
        txShift <= regRdata;
      end else if (strb.shiftOut) begin
        txBitQ  <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign txBit    = txBitQ;
  assign regAddr  = regAddrQ;
  assign regWe    = regWeQ;
  assign regRe    = regReQ;
  assign regWdata = regWdataQ;

  // R3: every commit is a single-cycle pulse
  a_r3_write_single: assert property (@(posedge clk) disable iff (!rstN)
    regWeQ |=> !regWeQ);

  // R3: reads and writes never share a cycle on the register port
  a_r3_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(regWeQ && regReQ));

  // R2: the register-file address always has its top bit clear
  a_r2_addr_top_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWeQ || regReQ) |-> (regAddrQ[REG_AW-1] == 1'b0));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              threeWire,
  input  logic              csN,
  input  logic              spc,
  input  logic              sdiIn,
  output logic              sdoData,
  output logic              sdoOe,
  output logic              sdioData,
  output logic              sdioOe,
  output logic [REG_AW-1:0] regAddr,
  output logic              regWe,
  output logic [DATA_W-1:0] regWdata,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  logic [2:0]        pinsS;
  ctlStrobe_t        strb;
  logic [ADDR_W-1:0] accessAddr;
  logic [DATA_W-1:0] rxNext;
  logic              txBit;
  logic              oe;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b110)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({csN, spc, sdiIn}),
    .syncOut(pinsS)
  );

  spi_reg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csS(pinsS[2]), .spcS(pinsS[1]),
    .rxNext(rxNext), .strb(strb),
    .accessAddr(accessAddr), .oe(oe)
  );

  spi_reg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rstN(rstN),
    .sdiS(pinsS[0]), .strb(strb), .accessAddr(accessAddr),
    .rxNext(rxNext), .txBit(txBit),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRe(regRe), .regRdata(regRdata)
  );

  assign sdoData  = txBit;
  assign sdioData = txBit;
  assign sdoOe    = oe && !threeWire;
  assign sdioOe   = oe && threeWire;

  // R8: only the enable of the selected pin arrangement may be active
  a_r8_one_enable: assert property (@(posedge clk) disable iff (!rstN)
    !(sdoOe && sdioOe));

endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;

  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic threeWire = 1'b0;
  logic csN = 1'b1;
  logic spc = 1'b1;
  logic sdiIn = 1'b0;
  logic sdoData, sdoOe, sdioData, sdioOe;
  logic [6:0] regAddr;
  logic regWe, regRe;
  logic [7:0] regWdata;
  logic [7:0] regRdata;

  always #2.5 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .threeWire(threeWire),
    .csN(csN), .spc(spc), .sdiIn(sdiIn),
    .sdoData(sdoData), .sdoOe(sdoOe), .sdioData(sdioData), .sdioOe(sdioOe),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRe(regRe), .regRdata(regRdata)
  );

  function automatic logic [7:0] initVal(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // register file model on the chip side
  logic [7:0] mem [128];
  int writeCount = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) mem[i] <= initVal(i);
      regRdata <= 8'h00;
    end else begin
      if (regWe) begin
        mem[regAddr] <= regWdata;
        writeCount <= writeCount + 1;
      end
      if (regRe) regRdata <= mem[regAddr];
    end
  end

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] txBuf [4];
  logic [7:0] rxBuf [4];
  int oeErrors;

  // one frame; stopAfter > 0 raises chip-select after that many bits
  task automatic runFrame(input logic rw, input logic ms, input logic [5:0] addr,
                          input int nBlocks, input int stopAfter);
    logic [7:0] cmd;
    int nBits;
    cmd = {rw, ms, addr};
    nBits = (stopAfter > 0) ? stopAfter : 8 + 8 * nBlocks;
    oeErrors = 0;
    for (int k = 0; k < 4; k++) rxBuf[k] = 8'h00;
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nBits; b++) begin
      spc = 1'b0;
      if (b < 8) sdiIn = cmd[7 - b];
      else if (!rw) sdiIn = txBuf[(b - 8) / 8][7 - ((b - 8) % 8)];
      else sdiIn = 1'b0;
      repeat (HALF) @(negedge clk);
      begin
        logic expOe;
        logic actOe, otherOe, bitVal;
        expOe   = rw && (b >= 8);
        actOe   = threeWire ? sdioOe : sdoOe;
        otherOe = threeWire ? sdoOe : sdioOe;
        bitVal  = threeWire ? sdioData : sdoData;
        if (actOe !== expOe || otherOe !== 1'b0) oeErrors++;
        if (b >= 8) rxBuf[(b - 8) / 8][7 - ((b - 8) % 8)] = bitVal;
      end
      spc = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    if (sdoOe !== 1'b0 || sdioOe !== 1'b0) oeErrors++;
  endtask

  task automatic testReset();
    check("R1 sdoOe", sdoOe, 0);
    check("R1 sdioOe", sdioOe, 0);
    check("R1 regWe", regWe, 0);
    check("R1 regRe", regRe, 0);
  endtask

  task automatic testSingleWrite();
    int w0;
    w0 = writeCount;
    txBuf[0] = 8'hA5;
    runFrame(1'b0, 1'b0, 6'h15, 1, 0);
    check("R3 single write data", mem[7'h15], 8'hA5);
    check("R3 single write pulse count", writeCount - w0, 1);
    check("R2 write address zero-extended", mem[7'h55], initVal(8'h55));
    check("R5 no drive during write", oeErrors, 0);
  endtask

  task automatic testSingleRead();
    runFrame(1'b1, 1'b0, 6'h2A, 1, 0);
    check("R4 single read data", rxBuf[0], initVal(8'h2A));
    check("R5 turnaround at bit 8", oeErrors, 0);
    runFrame(1'b1, 1'b0, 6'h15, 1, 0);
    check("R2 R4 read back written", rxBuf[0], 8'hA5);
  endtask

  task automatic testStepWrite();
    int w0;
    w0 = writeCount;
    txBuf[0] = 8'h3C; txBuf[1] = 8'hC3; txBuf[2] = 8'h5A;
    runFrame(1'b0, 1'b1, 6'h3E, 3, 0);
    check("R6 step write at 62", mem[62], 8'h3C);
    check("R6 step write at 63", mem[63], 8'hC3);
    check("R6 step write wraps to 0", mem[0], 8'h5A);
    check("R6 no write beyond 6 bits", mem[64], initVal(64));
    check("R6 write count", writeCount - w0, 3);
  endtask

  task automatic testStepRead();
    runFrame(1'b1, 1'b1, 6'h3E, 3, 0);
    check("R6 step read 62", rxBuf[0], 8'h3C);
    check("R6 step read 63", rxBuf[1], 8'hC3);
    check("R6 step read wrap 0", rxBuf[2], 8'h5A);
    check("R5 burst read enable", oeErrors, 0);
  endtask

  task automatic testFixedBurst();
    int w0;
    w0 = writeCount;
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33;
    runFrame(1'b0, 1'b0, 6'h05, 3, 0);
    check("R7 fixed write last wins", mem[5], 8'h33);
    check("R7 neighbour untouched", mem[6], initVal(6));
    check("R7 write count", writeCount - w0, 3);
    runFrame(1'b1, 1'b0, 6'h2A, 2, 0);
    check("R7 fixed read block 0", rxBuf[0], initVal(8'h2A));
    check("R7 fixed read block 1", rxBuf[1], initVal(8'h2A));
  endtask

  task automatic testThreeWire();
    threeWire = 1'b1;
    repeat (4) @(negedge clk);
    runFrame(1'b1, 1'b0, 6'h10, 1, 0);
    check("R8 shared pin read data", rxBuf[0], initVal(8'h10));
    check("R8 shared pin enable only", oeErrors, 0);
    txBuf[0] = 8'h96;
    runFrame(1'b0, 1'b0, 6'h11, 1, 0);
    check("R8 shared pin write", mem[7'h11], 8'h96);
    check("R8 shared pin write not driven", oeErrors, 0);
    threeWire = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testAbort();
    int w0;
    w0 = writeCount;
    txBuf[0] = 8'hEE;
    runFrame(1'b0, 1'b0, 6'h20, 1, 12);
    check("R9 partial byte not written", mem[7'h20], initVal(8'h20));
    check("R9 no write pulse", writeCount - w0, 0);
    txBuf[0] = 8'h77; txBuf[1] = 8'h88;
    runFrame(1'b0, 1'b1, 6'h21, 2, 19);
    check("R9 first byte kept", mem[7'h21], 8'h77);
    check("R9 second partial dropped", mem[7'h22], initVal(8'h22));
    check("R9 one write only", writeCount - w0, 1);
    runFrame(1'b1, 1'b0, 6'h30, 1, 5);
    check("R9 aborted command not driven", oeErrors, 0);
    runFrame(1'b1, 1'b0, 6'h21, 1, 0);
    check("R9 fresh frame decode", rxBuf[0], 8'h77);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testSingleWrite();
    testSingleRead();
    testStepWrite();
    testStepRead();
    testFixedBurst();
    testThreeWire();
    testAbort();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule